// File: doc/BRIEF.md
# Serial Memory Slave Byte Engine

This block is the protocol core of a two-wire serial memory slave holding 2048 bytes. A bus conditioner, which is not part of this block, turns the raw clock and data lines into single-cycle events: a start, a stop, and a sampled bit taken while the serial clock is high. The engine counts bits into bytes and checks the device identifier of the address byte. It loads the word address pointer and decides, one slot ahead, whether to pull the data line low for an acknowledge or for a zero data bit. A single output, `sda_low`, tells the pad logic to pull the line low for the slot that follows the last bit event.

Accepted write bytes go to a page-write controller as address and data strobes. The controller is told to start its write cycle by a commit pulse that follows the closing stop. Reads fetch bytes combinationally from the memory array through `mem_raddr` and `mem_rdata`. A busy flag from the write-cycle timer makes the device invisible on the bus, so a master can poll for the end of a write by sending address bytes until one is acknowledged. A write-protect input suppresses acknowledges on data bytes. The write-protect pin has an internal pull-down, so it reads low unless something drives it high.

Top module: `i2cmem_engine`

## Requirements
- R1: After reset the data line is released (`sda_low`=0), no write strobe or commit is issued, and the pointer is 0.
- R2: An address byte is acknowledged only if its bits 7..4 equal 4'b1010. Any other byte leaves the data line released for every slot until the next start.
- R3: While `busy` is 1 when the eighth address bit is sampled, the address byte is not acknowledged and the engine stays silent until the next start.
- R4: An acknowledged address byte copies its bits 3..1 into pointer bits 10..8. Bit 0 selects read (1) or write (0). In a write, the next byte is acknowledged and loaded into pointer bits 7..0.
- R5: Each later write-direction byte is acknowledged and issues `wr_valid` with the current pointer and the byte. The pointer's low 4 bits then wrap within the 16-byte page, and its upper bits stay fixed.
- R6: With `wp` at 1, the address and word-address bytes are still acknowledged. The first data byte is not acknowledged, and no strobe or commit follows. The pointer keeps the word address.
- R7: `wr_commit` pulses one cycle after a stop if at least one data byte was accepted since the last start. A repeated start discards the accepted bytes.
- R8: A read with no word address returns the byte at the pointer. The pointer points one past the last byte accessed by a read or a write.
- R9: A word-address byte, a repeated start and a read-direction address byte return the byte at the newly loaded address.
- R10: Read data is sent MSB first. After each byte the pointer steps across the full 11-bit range, wrapping from 0x7FF to 0x000. A master acknowledge (sampled 0 in the ninth slot) starts the next byte.
- R11: A master no-acknowledge (sampled 1) in the ninth read slot releases the line for every later slot until the next start.
- R12: A start or stop arriving within a byte releases the line on the next cycle and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | Start condition seen (one cycle) |
| stop_evt | input | 1 | Stop condition seen (one cycle) |
| bit_evt | input | 1 | A bit was sampled with the serial clock high |
| bit_val | input | 1 | Value of the sampled bit (wired-AND line level) |
| busy | input | 1 | Internal write cycle in progress |
| wp | input | 1 | Write protect, 1 = writes refused |
| mem_rdata | input | 8 | Array byte at `mem_raddr` |
| sda_low | output | 1 | Pull the data line low for the next slot |
| mem_raddr | output | 11 | Word address pointer, used as read address |
| wr_valid | output | 1 | Accepted write byte strobe |
| wr_addr | output | 11 | Address of the accepted byte |
| wr_data | output | 8 | Accepted byte |
| wr_commit | output | 1 | Start the page write cycle |

## Verification
The assertions rely on the bus conditioner delivering at most one event per cycle, and on start and stop never coinciding with a bit event. The bench drives every event as a one-cycle pulse with idle cycles in between. It computes `bit_val` as the wired-AND of the master's bit and the engine's previous `sda_low`, and it changes `busy` and `wp` only while the bus is idle between transfers.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam int BYTE_W   = 8;
    localparam int ACK_SLOT = 8;
    localparam int LAST_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_WORDADR,
        ST_WRDATA,
        ST_RDDATA,
        ST_IGNORE
    } eng_state_e;

    function automatic logic id_match(input logic [BYTE_W-1:0] b, input logic [3:0] id);
        return b[7:4] == id;
    endfunction

endpackage

// File: rtl/i2cmem_shift.sv
module i2cmem_shift
    import i2cmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_evt,
    input  logic             bit_val,
    input  logic             load,
    input  logic [6:0]       load_low,
    output logic [3:0]       cnt,
    output logic [BYTE_W-1:0] rx_full,
    output logic             tx_next
);
    logic [6:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            sh  <= '0;
        end else if (bit_evt) begin
            cnt <= (cnt == 4'(ACK_SLOT)) ? 4'd0 : cnt + 4'd1;
            if (load) sh <= load_low;
            else      sh <= {sh[5:0], bit_val};
        end
    end

    assign rx_full = {sh, bit_val};
    assign tx_next = sh[6];
endmodule

// File: rtl/i2cmem_ptr.sv
module i2cmem_ptr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_blk,
    input  logic [ADDR_W-9:0] blk,
    input  logic              ld_low,
    input  logic [7:0]        low,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] ptr
);
    localparam int BLK_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page_off;
    assign page_off = ptr[PAGE_W-1:0] + PAGE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ld_blk) begin
            ptr[ADDR_W-1 -: BLK_W] <= blk;
        end else if (ld_low) begin
            ptr[7:0] <= low;
        end else if (inc_page) begin
            ptr[PAGE_W-1:0] <= page_off;
        end else if (inc_full) begin
            ptr <= ptr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/i2cmem_engine.sv
module i2cmem_engine
    import i2cmem_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter int         PAGE_W = 4,
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_evt,
    input  logic              bit_val,
    input  logic              busy,
    input  logic              wp,
    input  logic [7:0]        mem_rdata,
    output logic              sda_low,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int BLK_W = ADDR_W - 8;

    eng_state_e        state;
    logic              is_rd;
    logic              wr_pend;
    logic [3:0]        cnt;
    logic [7:0]        rx;
    logic              tx_next;
    logic [ADDR_W-1:0] ptr;

    logic ev_ok, last_bit, ack_slot, addr_ok;
    logic ld_blk, ld_low, inc_page, inc_full, tx_load;

    assign ev_ok    = bit_evt && !start_evt && !stop_evt;
    assign last_bit = (cnt == 4'(LAST_BIT));
    assign ack_slot = (cnt == 4'(ACK_SLOT));
    assign addr_ok  = id_match(rx, DEV_ID) && !busy;

    assign ld_blk   = ev_ok && state == ST_DEVADR  && last_bit && addr_ok;
    assign ld_low   = ev_ok && state == ST_WORDADR && last_bit;
    assign inc_page = ev_ok && state == ST_WRDATA  && last_bit && !wp;
    assign inc_full = ev_ok && state == ST_RDDATA  && last_bit;
    assign tx_load  = ev_ok && ack_slot &&
                      ((state == ST_DEVADR && is_rd) || (state == ST_RDDATA && !bit_val));

    i2cmem_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_evt || stop_evt),
        .bit_evt  (bit_evt),
        .bit_val  (bit_val),
        .load     (tx_load),
        .load_low (mem_rdata[6:0]),
        .cnt      (cnt),
        .rx_full  (rx),
        .tx_next  (tx_next)
    );

    i2cmem_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ld_blk   (ld_blk),
        .blk      (rx[BLK_W:1]),
        .ld_low   (ld_low),
        .low      (rx),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .ptr      (ptr)
    );

    assign mem_raddr = ptr;

    always_ff @(posedge clk) begin
        wr_valid  <= 1'b0;
        wr_commit <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            sda_low <= 1'b0;
            is_rd   <= 1'b0;
            wr_pend <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (start_evt) begin
            state   <= ST_DEVADR;
            sda_low <= 1'b0;
            wr_pend <= 1'b0;
        end else if (stop_evt) begin
            state     <= ST_IDLE;
            sda_low   <= 1'b0;
            wr_commit <= wr_pend;
            wr_pend   <= 1'b0;
        end else if (bit_evt) begin
            unique case (state)
                ST_DEVADR: begin
                    if (last_bit) begin
                        if (addr_ok) begin
                            sda_low <= 1'b1;
                            is_rd   <= rx[0];
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end else if (ack_slot) begin
                        if (is_rd) begin
                            state   <= ST_RDDATA;
                            sda_low <= ~mem_rdata[7];
                        end else begin
                            state   <= ST_WORDADR;
                            sda_low <= 1'b0;
                        end
                    end
                end
                ST_WORDADR: begin
                    if (last_bit) begin
                        sda_low <= 1'b1;
                    end else if (ack_slot) begin
                        sda_low <= 1'b0;
                        state   <= ST_WRDATA;
                    end
                end
                ST_WRDATA: begin
                    if (last_bit) begin
                        if (!wp) begin
                            sda_low  <= 1'b1;
                            wr_valid <= 1'b1;
                            wr_addr  <= ptr;
                            wr_data  <= rx;
                            wr_pend  <= 1'b1;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end else if (ack_slot) begin
                        sda_low <= 1'b0;
                    end
                end
                ST_RDDATA: begin
                    if (last_bit) begin
                        sda_low <= 1'b0;
                    end else if (ack_slot) begin
                        if (!bit_val) begin
                            sda_low <= ~mem_rdata[7];
                        end else begin
                            sda_low <= 1'b0;
                            state   <= ST_IGNORE;
                        end
                    end else begin
                        sda_low <= ~tx_next;
                    end
                end
                default: sda_low <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk (
    input logic clk,
    input logic rst,
    input logic start_evt,
    input logic stop_evt,
    input logic bit_evt,
    input logic wp,
    input logic sda_low,
    input logic wr_valid,
    input logic wr_commit
);
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_low);

    a_r12_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !sda_low);

    a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_evt));

    a_r6_no_write_protected: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !$past(wp));

    a_r5_write_on_bit: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(bit_evt));

    a_r7_strobe_commit_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_valid, wr_commit}));
endmodule

bind i2cmem_engine i2cmem_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .bit_evt   (bit_evt),
    .wp        (wp),
    .sda_low   (sda_low),
    .wr_valid  (wr_valid),
    .wr_commit (wr_commit)
);

// File: tb/i2cmem_engine_tb_top.sv
`timescale 1ns/1ps
module i2cmem_engine_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_evt = 0, stop_evt = 0, bit_evt = 0, bit_val = 0, busy = 0, wp = 0;
    logic [7:0]  mem_rdata;
    logic        sda_low, wr_valid, wr_commit;
    logic [10:0] mem_raddr, wr_addr;
    logic [7:0]  wr_data;

    always #10 clk = ~clk;

    i2cmem_engine dut_i (
        .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_evt(bit_evt), .bit_val(bit_val), .busy(busy), .wp(wp),
        .mem_rdata(mem_rdata), .sda_low(sda_low), .mem_raddr(mem_raddr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit)
    );

    int n_chk = 0, n_fail = 0, commits = 0;
    logic [7:0]  mem [2048];
    logic [18:0] stage[$];
    logic [18:0] exp_q[$];

    function automatic logic [7:0] f(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    assign mem_rdata = mem[mem_raddr];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model, page-write staging and write monitor (scoreboard)
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2048; i++) mem[i] <= f(i);
        end else begin
            if (start_evt) stage.delete();
            if (wr_valid) begin
                stage.push_back({wr_addr, wr_data});
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5 unexpected write actual=%h expected=none", {wr_addr, wr_data});
                end else begin
                    logic [18:0] e;
                    e = exp_q.pop_front();
                    if (e !== {wr_addr, wr_data}) begin
                        n_fail++;
                        $display("FAIL R5 write actual=%h expected=%h", {wr_addr, wr_data}, e);
                    end
                end
            end
            if (wr_commit) begin
                commits++;
                foreach (stage[k]) mem[stage[k][18:8]] <= stage[k][7:0];
                stage.delete();
            end
        end
    end

    task automatic exp_write(logic [10:0] a, logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic slot(input logic m, output logic s);
        @(negedge clk);
        s = m & ~sda_low;
        bit_evt = 1'b1;
        bit_val = s;
        @(negedge clk);
        bit_evt = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) slot(b[i], s);
        slot(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            slot(1'b1, s);
            b = {b[6:0], s};
        end
        slot(~mack, s);
    endtask

    task automatic set_ptr(logic [10:0] a, string req);
        logic ack;
        do_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
        send_byte(a[7:0], ack);                   chk({req, " word ack"}, ack, 1);
    endtask

    task automatic rnd_read(logic [10:0] a, logic [7:0] exp, string req);
        logic ack;
        logic [7:0] b;
        set_ptr(a, req);
        do_start();
        send_byte({4'b1010, a[10:8], 1'b1}, ack);
        read_byte(1'b0, b);
        chk(req, b, exp);
        do_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sda released", sda_low, 0);
        chk("R1 no strobe", {wr_valid, wr_commit}, 0);

        // R1 R8: current read from reset pointer 0, then n+1
        do_start();
        send_byte(8'hA1, ack); chk("R2 id acked", ack, 1);
        read_byte(1'b0, b);    chk("R1 pointer zero", b, f(0));
        do_stop();
        do_start();
        send_byte(8'hA1, ack);
        read_byte(1'b0, b);    chk("R8 next address", b, f(1));
        do_stop();

        // R2: foreign identifier is ignored
        do_start();
        send_byte(8'hB0, ack); chk("R2 bad id nack", ack, 0);
        send_byte(8'h00, ack); chk("R2 silent after", ack, 0);
        do_stop();

        // R4 R5 R7: byte write
        exp_write(11'h235, 8'hA5);
        set_ptr(11'h235, "R4");
        send_byte(8'hA5, ack); chk("R5 data ack", ack, 1);
        do_stop();
        repeat (2) @(negedge clk);
        chk("R7 commit count", commits, 1);

        // R3: busy hides the device
        busy = 1'b1;
        do_start();
        send_byte(8'hA4, ack); chk("R3 busy nack", ack, 0);
        do_stop();
        busy = 1'b0;

        // R9 random read, R8 current read afterwards
        rnd_read(11'h235, 8'hA5, "R9 random read");
        do_start();
        send_byte(8'hA5, ack);
        read_byte(1'b0, b);    chk("R8 current after random", b, f(11'h236));
        do_stop();

        // R5 page wrap on write
        exp_write(11'h13E, 8'h11);
        exp_write(11'h13F, 8'h22);
        exp_write(11'h130, 8'h33);
        set_ptr(11'h13E, "R5");
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack); chk("R5 third ack", ack, 1);
        do_stop();
        repeat (2) @(negedge clk);
        chk("R7 second commit", commits, 2);
        rnd_read(11'h130, 8'h33, "R5 wrapped byte");
        set_ptr(11'h13F, "R10");
        do_start();
        send_byte(8'hA3, ack);
        read_byte(1'b1, b);    chk("R10 read 13F", b, 8'h22);
        read_byte(1'b0, b);    chk("R10 read steps past page", b, f(11'h140));
        do_stop();

        // R6 write protect
        wp = 1'b1;
        set_ptr(11'h150, "R6");
        send_byte(8'h77, ack); chk("R6 data nack", ack, 0);
        do_stop();
        repeat (2) @(negedge clk);
        chk("R6 no commit", commits, 2);
        wp = 1'b0;
        do_start();
        send_byte(8'hA3, ack);
        read_byte(1'b0, b);    chk("R6 pointer and data kept", b, f(11'h150));
        do_stop();

        // R7 repeated start discards
        exp_write(11'h310, 8'h3C);
        set_ptr(11'h310, "R7");
        send_byte(8'h3C, ack);
        do_start();
        send_byte(8'hA7, ack);
        read_byte(1'b0, b);    chk("R7 current after write", b, f(11'h311));
        do_stop();
        repeat (2) @(negedge clk);
        chk("R7 discarded no commit", commits, 2);
        rnd_read(11'h310, f(11'h310), "R7 memory unchanged");

        // R10 sequential wrap, R11 release after nack
        set_ptr(11'h7FE, "R10");
        do_start();
        send_byte(8'hAF, ack);
        read_byte(1'b1, b);    chk("R10 7FE", b, f(11'h7FE));
        read_byte(1'b1, b);    chk("R10 7FF", b, f(11'h7FF));
        read_byte(1'b1, b);    chk("R10 wrap 000", b, f(0));
        read_byte(1'b0, b);    chk("R10 001", b, f(1));
        read_byte(1'b1, b);    chk("R11 released after nack", b, 8'hFF);
        do_stop();

        // R12 aborted bytes keep the pointer (now 0x002)
        do_start();
        for (int i = 0; i < 4; i++) slot(i[0], ack);
        do_stop();
        @(negedge clk);
        chk("R12 released on stop", sda_low, 0);
        do_start();
        send_byte(8'hA0, ack);
        for (int i = 0; i < 5; i++) slot(1'b1, ack);
        do_start();
        @(negedge clk);
        chk("R12 released on start", sda_low, 0);
        send_byte(8'hA1, ack);
        read_byte(1'b0, b);    chk("R12 pointer unchanged", b, f(2));
        do_stop();

        repeat (3) @(negedge clk);
        chk("R5 all expected writes seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule